// File: doc/BRIEF.md
# Interrupt and Restart Sequencer

This block sits beside a processor core's control sequencer and decides which pending event the core services next. At machine-cycle boundaries it can hand the external bus to another master. At instruction boundaries it can divert the core to a non-maskable restart or to a maskable interrupt. It owns the interrupt-enable flag, the copy of that flag saved during a non-maskable service, the interrupt-mode register and the pending flag for the falling-edge non-maskable input.

The priority order is fixed. A bus request comes first, then a latched non-maskable edge, then the maskable request, which is taken only while interrupts are enabled. A taken event leads to a new program-counter value on a valid/ready jump channel. In the table mode the target is built from the vector-high register and a byte read during an acknowledge cycle. In the inject mode that byte is either a one-byte restart opcode or an opcode passed to the core for execution. The fixed mode needs no acknowledge byte.

The acknowledge channel follows valid/ready rules. `ack_req` acts as ready and stays high until the device presents `ack_vld`. The byte transfers in the cycle where both are high. The jump channel has `jmp_vld` as valid. Once raised, it stays high with `jmp_tgt` and `jmp_inj` unchanged until the core raises `jmp_rdy`. While the jump waits, the core may hold off `jmp_rdy` for as long as it likes, and no new event is accepted.

Top module: `irq_restart_seq`

## Requirements
- R1: The sequencer enters its reset state at every rising edge where `rst_n` has been sampled low on at least RST_HOLD (default 3) consecutive rising edges, counting the current one. Reset clears the enable flag, the saved flag and the pending non-maskable edge, selects mode 0 and returns to idle. A shorter low pulse changes no state. While `rst_n` is low, `bus_hiz` is 1, `busack_n` is 1, and `ack_req` and `jmp_vld` are 0. While `rst_n` is low no event is accepted and neither handshake completes.
- R2: In idle, a rising edge with `busreq_n`=0 at a cycle boundary grants the bus. A cycle boundary is `cyc_end`, `instr_end` or `halted` high. The grant shows as `busack_n`=0 and `bus_hiz`=1 from the next cycle. The grant holds while `busreq_n` stays low and ends on the first edge with `busreq_n`=1. A bus request wins over any interrupt at the same boundary, and nothing is granted without a boundary.
- R3: Sampling `nmi_n`=1 at one edge and 0 at the next sets a pending flag. The flag stays set if the pin rises again. A pending flag is taken at the next instruction boundary (`instr_end` or `halted`) in idle, whatever the enable flag holds and whether or not `int_n` is low. Taking it gives a jump to 0x0066 with `jmp_inj`=0.
- R4: Taking a non-maskable event copies the enable flag into the saved flag and clears the enable flag. `ie_ret` copies the saved flag back into the enable flag.
- R5: `int_n`=0 is accepted only at an instruction boundary in idle, and only with the enable flag set, no pending non-maskable edge and no bus grant. Acceptance clears the enable flag. While the flag is clear, `int_n` has no effect.
- R6: In mode 1 (`mode_sel` code 1), an accepted interrupt raises `jmp_vld` with target 0x0038 in the next cycle. No acknowledge cycle is run.
- R7: In mode 2 (code 2), `ack_req` rises in the cycle after acceptance and holds until `ack_vld`. The cycle after the transfer, the jump target is {`vec_hi`, `ack_byte`}, with both sampled at the transfer edge.
- R8: In mode 0 (code 0), a byte that matches 11xxx111 gives target = byte bits 5:3 times 8 with `jmp_inj`=0. Any other byte gives `jmp_inj`=1 with `jmp_tgt`={8'h00, byte}.
- R9: `jmp_vld` stays high with `jmp_tgt` and `jmp_inj` stable until an edge with `jmp_rdy`=1. It is low in the following cycle. `ack_req`, `jmp_vld` and the bus grant are never active together.
- R10: `mode_wr` with `mode_sel` 0, 1 or 2 loads the mode on the next edge. `mode_sel`=3 leaves the mode unchanged. The mode is latched when an interrupt is accepted.
- R11: `ie_on` sets both the enable flag and the saved flag, and `ie_off` clears both. `ie_off` wins over `ie_on` in the same cycle. Accepting an event wins over both.
- R12: While `halted` is high, every cycle counts as an instruction boundary. This lets a pending non-maskable edge or an enabled interrupt end the halt without `instr_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset request, qualified by hold length |
| busreq_n | input | 1 | Active-low external bus request |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| int_n | input | 1 | Active-low maskable request |
| cyc_end | input | 1 | Core is at the end of a machine cycle |
| instr_end | input | 1 | Core is at the end of an instruction |
| halted | input | 1 | Core is in the halt state |
| ie_on | input | 1 | Set enable and saved flags |
| ie_off | input | 1 | Clear enable and saved flags |
| ie_ret | input | 1 | Restore enable flag from saved flag |
| mode_wr | input | 1 | Load interrupt mode |
| mode_sel | input | 2 | Mode code: 0 inject, 1 fixed, 2 table |
| vec_hi | input | ADDR_W-BYTE_W | Vector-high register value |
| ack_req | output | 1 | Acknowledge cycle requested (ready) |
| ack_vld | input | 1 | Acknowledge byte valid |
| ack_byte | input | BYTE_W | Byte read during acknowledge |
| jmp_vld | output | 1 | Jump request valid |
| jmp_rdy | input | 1 | Core accepts jump |
| jmp_tgt | output | ADDR_W | Jump target, or opcode when injected |
| jmp_inj | output | 1 | Low byte of target is an opcode to execute |
| busack_n | output | 1 | Active-low bus grant |
| bus_hiz | output | 1 | Core's bus drivers must float |
| iff_q | output | 1 | Maskable-interrupt enable flag |

## Verification
The properties assume that every input is synchronous to `clk` and changes only between rising edges. They also assume that `rst_n` low means the outputs carry no meaning, so every property is switched off for any cycle in which the pin is low. The properties that look one cycle back also require that `rst_n` was high in that earlier cycle. The stimulus changes all inputs on the falling edge. The random stimulus includes short reset pulses and jump or acknowledge handshakes held back for several cycles. It also includes non-maskable pulses that rise again before service. None of these break the assumptions, so the properties are tested against stalls and frozen states and not only against the directed sequences.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_GRANT = 2'd1,
    SQ_ACK   = 2'd2,
    SQ_JUMP  = 2'd3
  } sq_state_t;

  localparam logic [1:0] IM_INJECT = 2'd0;
  localparam logic [1:0] IM_FIXED  = 2'd1;
  localparam logic [1:0] IM_TABLE  = 2'd2;
  localparam logic [1:0] IM_BAD    = 2'd3;

  localparam logic [15:0] NMI_TARGET   = 16'h0066;
  localparam logic [15:0] FIXED_TARGET = 16'h0038;
endpackage

// File: rtl/irq_rst_qual.sv
`timescale 1ns/1ps
module irq_rst_qual #(
  parameter int RST_HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_HOLD - 1);
  localparam logic [CW-1:0] SAT  = CW'(RST_HOLD);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst_n)              low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  // reset applies on the RST_HOLD-th consecutive low edge and later
  assign srst = !rst_n && (low_cnt >= LAST);
endmodule

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
module irq_edge_latch (
  input  logic clk,
  input  logic srst,
  input  logic pin_n,
  input  logic take,
  output logic pend
);
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= pin_n;
    if (srst)                 pend <= 1'b0;
    else if (prev_q && !pin_n) pend <= 1'b1;
    else if (take)            pend <= 1'b0;
  end
endmodule

// File: rtl/irq_iff_mode.sv
`timescale 1ns/1ps
module irq_iff_mode
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic       ie_on,
  input  logic       ie_off,
  input  logic       ie_ret,
  input  logic       take_nmi,
  input  logic       take_int,
  input  logic       mode_wr,
  input  logic [1:0] mode_sel,
  output logic       iff_q,
  output logic [1:0] mode_q
);
  logic save_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      iff_q  <= 1'b0;
      save_q <= 1'b0;
    end else if (take_nmi) begin
      save_q <= iff_q;
      iff_q  <= 1'b0;
    end else if (take_int) begin
      iff_q  <= 1'b0;
    end else if (ie_off) begin
      iff_q  <= 1'b0;
      save_q <= 1'b0;
    end else if (ie_on) begin
      iff_q  <= 1'b1;
      save_q <= 1'b1;
    end else if (ie_ret) begin
      iff_q  <= save_q;
    end
  end

  always_ff @(posedge clk) begin
    if (srst)                             mode_q <= IM_INJECT;
    else if (mode_wr && mode_sel != IM_BAD) mode_q <= mode_sel;
  end
endmodule

// File: rtl/irq_vec_gen.sv
`timescale 1ns/1ps
module irq_vec_gen
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [1:0]               mode,
  input  logic [ADDR_W-BYTE_W-1:0] vec_hi,
  input  logic [BYTE_W-1:0]        dbyte,
  output logic [ADDR_W-1:0]        tgt,
  output logic                     inj
);
  logic is_restart;

  always_comb begin
    is_restart = (dbyte[7:6] == 2'b11) && (dbyte[2:0] == 3'b111);
    tgt = '0;
    inj = 1'b0;
    if (mode == IM_TABLE) begin
      tgt = {vec_hi, dbyte};
    end else if (is_restart) begin
      tgt[5:3] = dbyte[5:3];
    end else begin
      tgt[BYTE_W-1:0] = dbyte;
      inj = 1'b1;
    end
  end
endmodule

// File: rtl/irq_restart_seq.sv
`timescale 1ns/1ps
module irq_restart_seq
  import irq_seq_pkg::*;
#(
  parameter int RST_HOLD = 3,
  parameter int ADDR_W   = 16,
  parameter int BYTE_W   = 8,
  localparam int HI_W    = ADDR_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busreq_n,
  input  logic              nmi_n,
  input  logic              int_n,
  input  logic              cyc_end,
  input  logic              instr_end,
  input  logic              halted,
  input  logic              ie_on,
  input  logic              ie_off,
  input  logic              ie_ret,
  input  logic              mode_wr,
  input  logic [1:0]        mode_sel,
  input  logic [HI_W-1:0]   vec_hi,
  output logic              ack_req,
  input  logic              ack_vld,
  input  logic [BYTE_W-1:0] ack_byte,
  output logic              jmp_vld,
  input  logic              jmp_rdy,
  output logic [ADDR_W-1:0] jmp_tgt,
  output logic              jmp_inj,
  output logic              busack_n,
  output logic              bus_hiz,
  output logic              iff_q
);
  sq_state_t          st_q;
  logic               srst;
  logic               nmi_pend;
  logic               cyc_bnd, ins_bnd, idle_live;
  logic               take_bus, take_nmi, take_int;
  logic [1:0]         mode_q, amode_q;
  logic [ADDR_W-1:0]  tgt_q, vec_tgt;
  logic               inj_q, vec_inj;

  irq_rst_qual #(.RST_HOLD(RST_HOLD)) u_rq (
    .clk(clk), .rst_n(rst_n), .srst(srst)
  );

  assign cyc_bnd   = cyc_end | instr_end | halted;
  assign ins_bnd   = instr_end | halted;
  assign idle_live = rst_n && (st_q == SQ_IDLE);
  assign take_bus  = idle_live && cyc_bnd && !busreq_n;
  assign take_nmi  = idle_live && ins_bnd && !take_bus && nmi_pend;
  assign take_int  = idle_live && ins_bnd && !take_bus && !nmi_pend
                     && !int_n && iff_q;

  irq_edge_latch u_nmi (
    .clk(clk), .srst(srst), .pin_n(nmi_n), .take(take_nmi), .pend(nmi_pend)
  );

  irq_iff_mode u_iff (
    .clk(clk), .srst(srst), .ie_on(ie_on), .ie_off(ie_off), .ie_ret(ie_ret),
    .take_nmi(take_nmi), .take_int(take_int), .mode_wr(mode_wr),
    .mode_sel(mode_sel), .iff_q(iff_q), .mode_q(mode_q)
  );

  irq_vec_gen #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_vec (
    .mode(amode_q), .vec_hi(vec_hi), .dbyte(ack_byte),
    .tgt(vec_tgt), .inj(vec_inj)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      st_q    <= SQ_IDLE;
      tgt_q   <= '0;
      inj_q   <= 1'b0;
      amode_q <= IM_INJECT;
    end else if (rst_n) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (take_bus) begin
            st_q <= SQ_GRANT;
          end else if (take_nmi) begin
            st_q  <= SQ_JUMP;
            tgt_q <= ADDR_W'(NMI_TARGET);
            inj_q <= 1'b0;
          end else if (take_int) begin
            amode_q <= mode_q;
            if (mode_q == IM_FIXED) begin
              st_q  <= SQ_JUMP;
              tgt_q <= ADDR_W'(FIXED_TARGET);
              inj_q <= 1'b0;
            end else begin
              st_q <= SQ_ACK;
            end
          end
        end
        SQ_GRANT: if (busreq_n) st_q <= SQ_IDLE;
        SQ_ACK: begin
          if (ack_vld) begin
            st_q  <= SQ_JUMP;
            tgt_q <= vec_tgt;
            inj_q <= vec_inj;
          end
        end
        SQ_JUMP: if (jmp_rdy) st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign ack_req  = rst_n && (st_q == SQ_ACK);
  assign jmp_vld  = rst_n && (st_q == SQ_JUMP);
  assign busack_n = !(rst_n && (st_q == SQ_GRANT));
  assign bus_hiz  = !rst_n || (st_q == SQ_GRANT);
  assign jmp_tgt  = tgt_q;
  assign jmp_inj  = inj_q;
endmodule

// File: rtl/irq_restart_seq_chk.sv
`timescale 1ns/1ps
module irq_restart_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busreq_n,
  input logic              busack_n,
  input logic              ack_req,
  input logic              ack_vld,
  input logic              jmp_vld,
  input logic              jmp_rdy,
  input logic [ADDR_W-1:0] jmp_tgt,
  input logic              iff_q
);
  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busack_n && $past(rst_n)) |-> !$past(busreq_n));

  p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_vld) |=> ack_req);

  p_jmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_vld && !jmp_rdy) |=> (jmp_vld && $stable(jmp_tgt)));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!busack_n, ack_req, jmp_vld}));

  p_accept_clears_iff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !$past(ack_req) && $past(rst_n)) |-> !iff_q);
endmodule

bind irq_restart_seq irq_restart_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .busack_n(busack_n),
  .ack_req(ack_req), .ack_vld(ack_vld), .jmp_vld(jmp_vld),
  .jmp_rdy(jmp_rdy), .jmp_tgt(jmp_tgt), .iff_q(iff_q)
);

// File: tb/sim_irq_restart_seq.sv
`timescale 1ns/1ps
module sim_irq_restart_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, busreq_n, nmi_n, int_n, cyc_end, instr_end, halted;
  logic ie_on, ie_off, ie_ret, mode_wr, ack_vld, jmp_rdy;
  logic [1:0]  mode_sel;
  logic [7:0]  vec_hi, ack_byte;
  logic        ack_req, jmp_vld, jmp_inj, busack_n, bus_hiz, iff_q;
  logic [15:0] jmp_tgt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_restart_seq u0 (
    .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .nmi_n(nmi_n),
    .int_n(int_n), .cyc_end(cyc_end), .instr_end(instr_end), .halted(halted),
    .ie_on(ie_on), .ie_off(ie_off), .ie_ret(ie_ret), .mode_wr(mode_wr),
    .mode_sel(mode_sel), .vec_hi(vec_hi), .ack_req(ack_req),
    .ack_vld(ack_vld), .ack_byte(ack_byte), .jmp_vld(jmp_vld),
    .jmp_rdy(jmp_rdy), .jmp_tgt(jmp_tgt), .jmp_inj(jmp_inj),
    .busack_n(busack_n), .bus_hiz(bus_hiz), .iff_q(iff_q)
  );

  // ---------------- reference model from the requirements ----------------
  logic [1:0]  m_cnt = 2'd0;
  logic [1:0]  m_st = 2'd0;      // 0 idle, 1 grant, 2 ack, 3 jump
  logic        m_prev = 1'b1, m_pend = 1'b0, m_iff = 1'b0, m_sav = 1'b0;
  logic [1:0]  m_mode = 2'd0, m_amode = 2'd0;
  logic [15:0] m_tgt = 16'h0;
  logic        m_inj = 1'b0;
  logic        m_srst, m_cb, m_ib, m_tb, m_tn, m_ti;
  logic [16:0] m_vec;

  function automatic logic [16:0] exp_target(logic [1:0] md, logic [7:0] hi,
                                             logic [7:0] b);
    if (md == 2'd2) return {1'b0, hi, b};
    if (b[7:6] == 2'b11 && b[2:0] == 3'b111) return {1'b0, 10'd0, b[5:3], 3'd0};
    return {1'b1, 8'h00, b};
  endfunction

  always @(posedge clk) begin
    m_srst = !rst_n && (m_cnt >= 2'd2);
    m_cb = cyc_end | instr_end | halted;
    m_ib = instr_end | halted;
    m_tb = rst_n && m_st == 2'd0 && m_cb && !busreq_n;
    m_tn = rst_n && m_st == 2'd0 && m_ib && !m_tb && m_pend;
    m_ti = rst_n && m_st == 2'd0 && m_ib && !m_tb && !m_pend && !int_n && m_iff;
    m_vec = exp_target(m_amode, vec_hi, ack_byte);
    m_cnt <= rst_n ? 2'd0 : (m_cnt == 2'd3 ? 2'd3 : m_cnt + 2'd1);
    m_prev <= nmi_n;
    if (m_srst) begin
      m_st <= 2'd0; m_pend <= 1'b0; m_iff <= 1'b0; m_sav <= 1'b0;
      m_mode <= 2'd0; m_amode <= 2'd0; m_tgt <= 16'h0; m_inj <= 1'b0;
    end else begin
      if (m_prev && !nmi_n) m_pend <= 1'b1;
      else if (m_tn)        m_pend <= 1'b0;
      if (m_tn) begin m_sav <= m_iff; m_iff <= 1'b0; end
      else if (m_ti) m_iff <= 1'b0;
      else if (ie_off) begin m_iff <= 1'b0; m_sav <= 1'b0; end
      else if (ie_on) begin m_iff <= 1'b1; m_sav <= 1'b1; end
      else if (ie_ret) m_iff <= m_sav;
      if (mode_wr && mode_sel != 2'd3) m_mode <= mode_sel;
      if (rst_n) begin
        case (m_st)
          2'd0: begin
            if (m_tb) m_st <= 2'd1;
            else if (m_tn) begin m_st <= 2'd3; m_tgt <= 16'h0066; m_inj <= 1'b0; end
            else if (m_ti) begin
              m_amode <= m_mode;
              if (m_mode == 2'd1) begin m_st <= 2'd3; m_tgt <= 16'h0038; m_inj <= 1'b0; end
              else m_st <= 2'd2;
            end
          end
          2'd1: if (busreq_n) m_st <= 2'd0;
          2'd2: if (ack_vld) begin m_st <= 2'd3; m_tgt <= m_vec[15:0]; m_inj <= m_vec[16]; end
          default: if (jmp_rdy) m_st <= 2'd0;
        endcase
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    expect_eq("R2 busack_n", {31'd0, busack_n}, {31'd0, !(rst_n && m_st == 2'd1)});
    expect_eq("R1 bus_hiz", {31'd0, bus_hiz}, {31'd0, !rst_n || m_st == 2'd1});
    expect_eq("R7 ack_req", {31'd0, ack_req}, {31'd0, rst_n && m_st == 2'd2});
    expect_eq("R9 jmp_vld", {31'd0, jmp_vld}, {31'd0, rst_n && m_st == 2'd3});
    expect_eq("R11 iff_q", {31'd0, iff_q}, {31'd0, m_iff});
    if (m_st == 2'd3)
      expect_eq("R8 jmp_tgt/inj", {15'd0, jmp_inj, jmp_tgt}, {15'd0, m_inj, m_tgt});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic quiet();
    busreq_n = 1; int_n = 1; cyc_end = 0; instr_end = 0; halted = 0;
    ie_on = 0; ie_off = 0; ie_ret = 0; mode_wr = 0; mode_sel = 0;
    ack_vld = 0; jmp_rdy = 0;
  endtask

  task automatic set_mode(logic [1:0] m);
    mode_wr = 1; mode_sel = m; tick(); mode_wr = 0;
  endtask

  task automatic enable();
    ie_on = 1; tick(); ie_on = 0;
  endtask

  task automatic drain();
    jmp_rdy = 1; tick(); jmp_rdy = 0;
  endtask

  task automatic raise_int();   // one instruction boundary with int_n low
    int_n = 0; instr_end = 1; tick(); int_n = 1; instr_end = 0;
  endtask

  task automatic give_byte(logic [7:0] hi, logic [7:0] b);
    vec_hi = hi; ack_byte = b; ack_vld = 1; tick(); ack_vld = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    quiet(); nmi_n = 1; vec_hi = 8'h00; ack_byte = 8'h00; rst_n = 0;
    @(negedge clk);
    repeat (4) tick();
    expect_eq("R1 hiz during reset", {31'd0, bus_hiz}, 32'd1);
    rst_n = 1; tick();
    expect_eq("R1 reset idle busack", {31'd0, busack_n}, 32'd1);
    expect_eq("R1 reset iff clear", {31'd0, iff_q}, 32'd0);
    expect_eq("R1 bus released", {31'd0, bus_hiz}, 32'd0);

    // R1: short pulse keeps state, full-length pulse clears it
    enable();
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
    expect_eq("R1 short pulse ignored", {31'd0, iff_q}, 32'd1);
    rst_n = 0; tick(); tick(); tick(); rst_n = 1; tick();
    expect_eq("R1 held reset clears iff", {31'd0, iff_q}, 32'd0);

    // R5: INT ignored while disabled
    raise_int();
    expect_eq("R5 int masked no ack", {31'd0, ack_req}, 32'd0);
    expect_eq("R5 int masked no jump", {31'd0, jmp_vld}, 32'd0);

    // R6 + R9: fixed mode and held jump
    set_mode(2'd1); enable();
    raise_int();
    expect_eq("R6 fixed jump valid", {31'd0, jmp_vld}, 32'd1);
    expect_eq("R6 fixed target", {16'd0, jmp_tgt}, 32'h0038);
    expect_eq("R6 no ack cycle", {31'd0, ack_req}, 32'd0);
    expect_eq("R5 accept clears iff", {31'd0, iff_q}, 32'd0);
    tick(); tick();
    expect_eq("R9 jump held", {31'd0, jmp_vld}, 32'd1);
    expect_eq("R9 target stable", {16'd0, jmp_tgt}, 32'h0038);
    drain();
    expect_eq("R9 jump dropped", {31'd0, jmp_vld}, 32'd0);

    // R7: table mode with a waiting device
    set_mode(2'd2); enable();
    raise_int();
    expect_eq("R7 ack requested", {31'd0, ack_req}, 32'd1);
    tick();
    expect_eq("R7 ack held", {31'd0, ack_req}, 32'd1);
    give_byte(8'h12, 8'h5A);
    expect_eq("R7 table target", {16'd0, jmp_tgt}, 32'h125A);
    drain();

    // R10: code 3 leaves table mode selected
    set_mode(2'd3); enable();
    raise_int();
    give_byte(8'h40, 8'hEF);
    expect_eq("R10 code 3 ignored", {16'd0, jmp_tgt}, 32'h40EF);
    drain();

    // R8: inject mode, restart byte and plain opcode
    set_mode(2'd0); enable();
    raise_int();
    give_byte(8'h40, 8'hEF);
    expect_eq("R8 restart target", {16'd0, jmp_tgt}, 32'h0028);
    expect_eq("R8 restart not injected", {31'd0, jmp_inj}, 32'd0);
    drain();
    enable(); raise_int();
    give_byte(8'h40, 8'h3E);
    expect_eq("R8 injected opcode", {15'd0, jmp_inj, jmp_tgt}, 32'h1003E);
    drain();

    // R3 + R4: pending edge survives pin release, beats INT, saves IFF
    enable();
    nmi_n = 0; tick(); nmi_n = 1; tick(); tick();
    expect_eq("R3 no boundary no jump", {31'd0, jmp_vld}, 32'd0);
    int_n = 0; instr_end = 1; tick(); int_n = 1; instr_end = 0;
    expect_eq("R3 nmi target", {16'd0, jmp_tgt}, 32'h0066);
    expect_eq("R3 nmi jump valid", {31'd0, jmp_vld}, 32'd1);
    expect_eq("R4 nmi clears iff", {31'd0, iff_q}, 32'd0);
    drain();
    ie_ret = 1; tick(); ie_ret = 0;
    expect_eq("R4 restore iff", {31'd0, iff_q}, 32'd1);

    // R3: taken with IFF clear
    ie_off = 1; tick(); ie_off = 0;
    nmi_n = 0; tick(); nmi_n = 1;
    instr_end = 1; tick(); instr_end = 0;
    expect_eq("R3 nmi ignores iff", {16'd0, jmp_tgt}, 32'h0066);
    drain();

    // R2: request waits for boundary and outranks pending NMI
    nmi_n = 0; tick(); nmi_n = 1;
    busreq_n = 0; tick();
    expect_eq("R2 no grant off boundary", {31'd0, busack_n}, 32'd1);
    instr_end = 1; tick(); instr_end = 0;
    expect_eq("R2 grant", {31'd0, busack_n}, 32'd0);
    expect_eq("R2 float", {31'd0, bus_hiz}, 32'd1);
    expect_eq("R2 beats nmi", {31'd0, jmp_vld}, 32'd0);
    tick();
    expect_eq("R2 grant held", {31'd0, busack_n}, 32'd0);
    busreq_n = 1; tick();
    expect_eq("R2 grant released", {31'd0, busack_n}, 32'd1);
    instr_end = 1; tick(); instr_end = 0;
    expect_eq("R3 pending kept through grant", {16'd0, jmp_tgt}, 32'h0066);
    drain();

    // R12: halt acts as instruction boundary
    set_mode(2'd1); enable();
    halted = 1; int_n = 0; tick(); int_n = 1; halted = 0;
    expect_eq("R12 halt exit by int", {15'd0, jmp_vld, jmp_tgt}, 32'h10038);
    drain();

    // R11: off wins over on
    ie_on = 1; ie_off = 1; tick(); ie_on = 0; ie_off = 0;
    expect_eq("R11 off wins", {31'd0, iff_q}, 32'd0);

    // random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      rst_n     = ($urandom % 100) != 0;
      busreq_n  = ($urandom % 10) != 0;
      if (($urandom % 12) == 0) nmi_n = ~nmi_n;
      int_n     = ($urandom % 3) != 0;
      cyc_end   = ($urandom % 3) == 0;
      instr_end = ($urandom % 5) == 0;
      halted    = ($urandom % 20) == 0;
      ie_on     = ($urandom % 8) == 0;
      ie_off    = ($urandom % 20) == 0;
      ie_ret    = ($urandom % 20) == 0;
      mode_wr   = ($urandom % 10) == 0;
      mode_sel  = 2'($urandom);
      vec_hi    = 8'($urandom);
      ack_byte  = ($urandom % 2) ? (8'hC7 | 8'($urandom & 32'h38)) : 8'($urandom);
      ack_vld   = ($urandom % 2) == 0;
      jmp_rdy   = ($urandom % 5) < 3;
      tick();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule